// File: doc/BRIEF.md
# I2C Write-Only Twelve-Channel DAC Code Register Bank

This block is an I2C target that only accepts writes. It keeps twelve 8-bit code registers, one for each channel of an external bank of digital-to-analogue converters. A code N sets the channel output to the low reference plus N/256 of the reference span. Code 00 therefore gives the low reference, and code FF gives 255/256 of the span. The bus lines are sampled by a fast system clock. Each line goes through a two-flop synchroniser and then a stable-count filter. Start, stop and SCL edges are detected from the filtered values.

A transaction has five parts:
- a start condition;
- an address byte, which carries the 7-bit address and the direction bit;
- a channel-select byte;
- one or more data bytes;
- a stop condition.

Each byte the block accepts is acknowledged by pulling SDA low. The pull is made through an open-drain enable output during the ninth clock. The low nibble of the channel-select byte picks one of four actions:
- write one channel;
- write the same byte to all channels;
- fill the channels one after another from channel 1, wrapping after channel 12;
- do nothing.

Inside the block, accepted bytes pass from the bus engine to the register bank as single-cycle valid beats. The bank has no ready signal and takes every beat in the cycle it is presented. No back-pressure reaches the bus, and the engine never stretches SCL.

Top module: `i2c_dac_regbank`

## Requirements
- R1: The block acknowledges an address byte only if its upper seven bits equal binary 1001 followed by strap_i[2:0] (strap_i[2] first), and its last bit (direction) is 0. For any other address byte, SDA stays released for the rest of the transaction and no channel register changes, until the next start condition.
- R2: The acknowledge drive is switched on at the falling SCL edge that ends bit 8. It is switched off at the falling SCL edge that ends the ninth clock. It never rises while the filtered SCL is high.
- R3: A channel-select byte whose low nibble is 1 to 12 writes the first data byte that follows into channel 1 to 12. The upper nibble is ignored. Later data bytes in the same transaction are acknowledged and discarded.
- R4: Low nibble 0 writes the first data byte into all twelve channels. Later data bytes are acknowledged and discarded.
- R5: Low nibble 15 writes successive data bytes to channels 1, 2, ... 12. After channel 12 it continues at channel 1, until a start or stop condition arrives.
- R6: Low nibbles 13 and 14 change no channel register. Their data bytes are still acknowledged.
- R7: A start condition in the middle of a transaction aborts it and restarts address reception, and writes already made are kept. A stop condition releases SDA.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks, after synchronisation, is ignored.
- R9: Reset clears all twelve codes to 00 and releases SDA.
- R10: codes_o carries channel k (1 to 12) on bits [8k-1:8k-8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 3 | Fixed strap pins that form the low address bits |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| codes_o | output | 96 | Twelve 8-bit channel codes, channel 1 in the lowest byte |

## Verification
The falling SCL edge that completes a data byte does two things in the same system clock: it hands the beat to the register bank, and it raises the acknowledge drive. Every data byte sent by the bench exercises this. The bench judges it twice: from the acknowledge level read off the wired-AND bus at the ninth clock, and from the full code set compared against a bench model once the transaction ends. A second coincidence is a repeated start that lands while a sequential fill is part-way through. The bench aborts a fill after three bytes and opens a single-channel write at once. It then expects the three early channels to hold the fill data and the new channel to hold the new byte.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;
  typedef enum logic [1:0] {
    FILL_NONE,
    FILL_ONE,
    FILL_ALL,
    FILL_SEQ
  } fill_mode_e;

  typedef enum logic [2:0] {
    L_IDLE,
    L_ADDR,
    L_CMD,
    L_DATA,
    L_SKIP
  } link_state_e;

  localparam logic [3:0] ADDR_FIXED = 4'b1001;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2cdac_deglitch.sv
module i2cdac_deglitch #(
  parameter int LINES    = 2,
  parameter int FILT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] clean_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= 2'b11;
        cnt_q  <= '0;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[g]};
        if (sync_q[1] == out_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign clean_o[g] = out_q;
  end
endmodule

// File: rtl/i2cdac_link.sv
module i2cdac_link
  import i2cdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              beat_valid_o,
  output logic              beat_cmd_o,
  output logic [BYTE_W-1:0] beat_data_o
);
  link_state_e       st_q;
  logic              scl_q, sda_q;
  logic [3:0]        bits_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              in_ack_q;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              busy;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign busy      = (st_q == L_ADDR) || (st_q == L_CMD) || (st_q == L_DATA);
  assign start_o   = start_det;
  assign stop_o    = stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= L_IDLE;
      scl_q        <= 1'b1;
      sda_q        <= 1'b1;
      bits_q       <= '0;
      shreg_q      <= '0;
      in_ack_q     <= 1'b0;
      sda_oe_o     <= 1'b0;
      beat_valid_o <= 1'b0;
      beat_cmd_o   <= 1'b0;
      beat_data_o  <= '0;
    end else begin
      scl_q        <= scl_i;
      sda_q        <= sda_i;
      beat_valid_o <= 1'b0;
      if (start_det) begin
        st_q     <= L_ADDR;
        bits_q   <= '0;
        in_ack_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st_q     <= L_IDLE;
        bits_q   <= '0;
        in_ack_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (busy) begin
        if (scl_rise && !in_ack_q && bits_q != 4'd8) begin
          shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
          bits_q  <= bits_q + 4'd1;
        end
        if (scl_fall) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            sda_oe_o <= 1'b0;
            bits_q   <= '0;
          end else if (bits_q == 4'd8) begin
            in_ack_q <= 1'b1;
            case (st_q)
              L_ADDR: begin
                if (shreg_q == {ADDR_FIXED, strap_i, 1'b0}) begin
                  sda_oe_o <= 1'b1;
                  st_q     <= L_CMD;
                end else begin
                  st_q <= L_SKIP;
                end
              end
              L_CMD: begin
                sda_oe_o     <= 1'b1;
                beat_valid_o <= 1'b1;
                beat_cmd_o   <= 1'b1;
                beat_data_o  <= shreg_q;
                st_q         <= L_DATA;
              end
              L_DATA: begin
                sda_oe_o     <= 1'b1;
                beat_valid_o <= 1'b1;
                beat_cmd_o   <= 1'b0;
                beat_data_o  <= shreg_q;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cdac_bank.sv
module i2cdac_bank
  import i2cdac_pkg::*;
#(
  parameter int CHANNELS = 12,
  parameter int CODE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       beat_valid_i,
  input  logic                       beat_cmd_i,
  input  logic [CODE_W-1:0]          beat_data_i,
  output logic [CHANNELS*CODE_W-1:0] codes_o
);
  localparam int PTR_W = $clog2(CHANNELS);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(CHANNELS - 1);

  fill_mode_e        mode_q;
  logic [PTR_W-1:0]  tgt_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [3:0]        nib;
  logic              data_beat;
  logic [CHANNELS-1:0] wr_en;

  assign nib       = beat_data_i[3:0];
  assign data_beat = beat_valid_i & ~beat_cmd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FILL_NONE;
      tgt_q  <= '0;
      ptr_q  <= '0;
    end else if (beat_valid_i && beat_cmd_i) begin
      ptr_q <= '0;
      if (nib == 4'd0) begin
        mode_q <= FILL_ALL;
      end else if (nib == 4'hF) begin
        mode_q <= FILL_SEQ;
      end else if (int'(nib) <= CHANNELS) begin
        mode_q <= FILL_ONE;
        tgt_q  <= PTR_W'(nib - 4'd1);
      end else begin
        mode_q <= FILL_NONE;
      end
    end else if (data_beat) begin
      if (mode_q == FILL_SEQ) begin
        ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      end else begin
        mode_q <= FILL_NONE;
      end
    end
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic [CODE_W-1:0] code_q;

    assign wr_en[g] = data_beat &&
                      ((mode_q == FILL_ALL) ||
                       (mode_q == FILL_ONE && tgt_q == PTR_W'(g)) ||
                       (mode_q == FILL_SEQ && ptr_q == PTR_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
      end else if (wr_en[g]) begin
        code_q <= beat_data_i;
      end
    end

    assign codes_o[g*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/i2c_dac_regbank.sv
module i2c_dac_regbank
  import i2cdac_pkg::*;
#(
  parameter int CHANNELS = 12,
  parameter int CODE_W   = 8,
  parameter int FILT_CYC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [2:0]                 strap_i,
  output logic                       sda_oe_o,
  output logic [CHANNELS*CODE_W-1:0] codes_o
);
  logic [1:0]        clean;
  logic              scl_f, sda_f;
  logic              start_det, stop_det;
  logic              beat_valid, beat_is_cmd;
  logic [BYTE_W-1:0] beat_data;

  i2cdac_deglitch #(.LINES(2), .FILT_CYC(FILT_CYC)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .clean_o(clean)
  );

  assign scl_f = clean[1];
  assign sda_f = clean[0];

  i2cdac_link u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_f),
    .sda_i       (sda_f),
    .strap_i     (strap_i),
    .sda_oe_o    (sda_oe_o),
    .start_o     (start_det),
    .stop_o      (stop_det),
    .beat_valid_o(beat_valid),
    .beat_cmd_o  (beat_is_cmd),
    .beat_data_o (beat_data)
  );

  i2cdac_bank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_valid_i(beat_valid),
    .beat_cmd_i  (beat_is_cmd),
    .beat_data_i (beat_data[CODE_W-1:0]),
    .codes_o     (codes_o)
  );
endmodule

// File: rtl/i2c_dac_regbank_chk.sv
module i2c_dac_regbank_chk #(
  parameter int CHANNELS = 12,
  parameter int CODE_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_f,
  input logic                       sda_oe,
  input logic                       start_det,
  input logic                       stop_det,
  input logic                       beat_valid,
  input logic                       beat_is_cmd,
  input logic [7:0]                 beat_data,
  input logic [CHANNELS*CODE_W-1:0] codes
);
  logic [3:0] last_nib_q;
  logic       data_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_nib_q  <= 4'hD;
      data_seen_q <= 1'b0;
    end else if (beat_valid && beat_is_cmd) begin
      last_nib_q  <= beat_data[3:0];
      data_seen_q <= 1'b0;
    end else if (beat_valid) begin
      data_seen_q <= 1'b1;
    end
  end

  p_reset_clear_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> (codes == '0 && !sda_oe));

  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || start_det) |=> !sda_oe);

  p_reserved_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_is_cmd && (last_nib_q == 4'hD || last_nib_q == 4'hE))
      |=> $stable(codes));

  p_bcast_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_is_cmd && last_nib_q == 4'h0 && !data_seen_q)
      |=> codes == {CHANNELS{$past(beat_data[CODE_W-1:0])}});
endmodule

bind i2c_dac_regbank i2c_dac_regbank_chk #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_f      (scl_f),
  .sda_oe     (sda_oe_o),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .beat_valid (beat_valid),
  .beat_is_cmd(beat_is_cmd),
  .beat_data  (beat_data),
  .codes      (codes_o)
);

// File: tb/tb_i2c_dac_regbank.sv
module tb_i2c_dac_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;
  localparam int NCH        = 12;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MY    = {4'b1001, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1;
  logic sda_d = 1'b1;
  logic sda_oe;
  logic [NCH*8-1:0] codes;
  wire  sda_bus = sda_d & ~sda_oe;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] expc [NCH];
  logic [7:0] buf_d [16];

  i2c_dac_regbank dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_d),
    .sda_i   (sda_bus),
    .strap_i (STRAP),
    .sda_oe_o(sda_oe),
    .codes_o (codes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) chk(tag, 32'(codes[c*8 +: 8]), 32'(expc[c]));
  endtask

  task automatic bus_start();
    sda_d = 1'b1; hold(Q);
    scl_d = 1'b1; hold(Q);
    sda_d = 1'b0; hold(Q);
    scl_d = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    sda_d = 1'b0; hold(Q);
    scl_d = 1'b1; hold(Q);
    sda_d = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack, output bit oe_after);
    for (int i = 7; i >= 0; i--) begin
      sda_d = b[i]; hold(Q);
      if (glitch && i == 4) begin
        scl_d = 1'b1; hold(2);
        scl_d = 1'b0; hold(Q);
      end
      scl_d = 1'b1; hold(Q);
      scl_d = 1'b0; hold(4);
    end
    sda_d = 1'b1; hold(Q);
    scl_d = 1'b1; hold(Q/2);
    ack = ~sda_bus;
    hold(Q/2);
    scl_d = 1'b0; hold(12);
    oe_after = sda_oe;
  endtask

  task automatic model(input logic [7:0] cmd, input int n);
    logic [3:0] nib;
    nib = cmd[3:0];
    if (n > 0) begin
      if (nib == 4'd0) begin
        for (int c = 0; c < NCH; c++) expc[c] = buf_d[0];
      end else if (nib <= 4'd12) begin
        expc[nib - 4'd1] = buf_d[0];
      end else if (nib == 4'hF) begin
        for (int k = 0; k < n; k++) expc[k % NCH] = buf_d[k];
      end
    end
  endtask

  task automatic xfer(input logic [6:0] a, input bit rw, input logic [7:0] cmd, input int n,
                      input bit glitch, input bit do_stop, input string tag);
    bit match, ack, oe_after;
    match = (a == MY) && !rw;
    bus_start();
    send_byte({a, rw}, 1'b0, ack, oe_after);
    chk({tag, " R1 addr ack"}, 32'(ack), 32'(match));
    chk({tag, " R2 ack released"}, 32'(oe_after), 32'd0);
    send_byte(cmd, 1'b0, ack, oe_after);
    chk({tag, " cmd ack"}, 32'(ack), 32'(match));
    for (int k = 0; k < n; k++) begin
      send_byte(buf_d[k], glitch && k == 0, ack, oe_after);
      chk({tag, " data ack"}, 32'(ack), 32'(match));
      chk({tag, " R2 ack released"}, 32'(oe_after), 32'd0);
    end
    if (match) model(cmd, n);
    if (do_stop) begin
      bus_stop();
      chk({tag, " R7 SDA released after stop"}, 32'(sda_oe), 32'd0);
    end
    check_all({tag, " codes"});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    for (int c = 0; c < NCH; c++) expc[c] = 8'h00;
    hold(5);
    chk("R9 reset SDA", 32'(sda_oe), 32'd0);
    check_all("R9 reset codes");
    rst_n = 1'b1;
    hold(10);

    buf_d[0] = 8'hA5;
    xfer(MY, 1'b0, 8'hA3, 1, 1'b0, 1'b1, "R3 single ch3 R10");
    buf_d[0] = 8'h3C; buf_d[1] = 8'h11; buf_d[2] = 8'h22;
    xfer(MY, 1'b0, 8'h07, 3, 1'b0, 1'b1, "R3 single ch7 extra discarded");
    buf_d[0] = 8'h0C;
    xfer(MY, 1'b0, 8'h6C, 1, 1'b0, 1'b1, "R3 single ch12");
    buf_d[0] = 8'h5A; buf_d[1] = 8'hEE;
    xfer(MY, 1'b0, 8'h50, 2, 1'b0, 1'b1, "R4 broadcast");
    for (int k = 0; k < 14; k++) buf_d[k] = 8'(8'h40 + k * 3);
    xfer(MY, 1'b0, 8'h0F, 14, 1'b0, 1'b1, "R5 sequential wrap");
    buf_d[0] = 8'hFF; buf_d[1] = 8'h00;
    xfer(MY, 1'b0, 8'h0D, 2, 1'b0, 1'b1, "R6 reserved 13");
    xfer(MY, 1'b0, 8'h3E, 1, 1'b0, 1'b1, "R6 reserved 14");
    buf_d[0] = 8'h77;
    xfer(MY ^ 7'h01, 1'b0, 8'h02, 1, 1'b0, 1'b1, "R1 strap mismatch");
    xfer({4'b0001, STRAP}, 1'b0, 8'h02, 1, 1'b0, 1'b1, "R1 fixed bits mismatch");
    xfer(MY, 1'b1, 8'h02, 1, 1'b0, 1'b1, "R1 read refused");
    buf_d[0] = 8'h91; buf_d[1] = 8'h92; buf_d[2] = 8'h93;
    xfer(MY, 1'b0, 8'h0F, 3, 1'b0, 1'b0, "R7 fill before abort");
    buf_d[0] = 8'hB9;
    xfer(MY, 1'b0, 8'h09, 1, 1'b0, 1'b1, "R7 write after repeated start");
    xfer(MY, 1'b0, 8'h04, 0, 1'b0, 1'b0, "R7 cmd only then abort");
    buf_d[0] = 8'hC4;
    xfer(MY, 1'b0, 8'h04, 1, 1'b0, 1'b1, "R7 restart address");
    buf_d[0] = 8'h6B;
    xfer(MY, 1'b0, 8'h0B, 1, 1'b1, 1'b1, "R8 SCL glitch ignored");

    for (int t = 0; t < 20; t++) begin
      logic [6:0] a;
      bit rw;
      logic [7:0] cmd;
      int n;
      a   = (($urandom % 8) == 0) ? 7'($urandom) : MY;
      rw  = (($urandom % 10) == 0);
      cmd = 8'($urandom);
      n   = 1 + int'($urandom % 15);
      for (int k = 0; k < 16; k++) buf_d[k] = 8'($urandom);
      xfer(a, rw, cmd, n, 1'b0, 1'b1, "R3 R4 R5 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule